// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block adds or subtracts two 64-bit words that each hold several independent integer lanes. A lane-size select splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Carries and borrows never leave their own lane.

An arithmetic select picks one of three behaviours for each lane when a result falls outside the lane's range:
- **Wrap:** keep the low bits of the result.
- **Unsigned clamp:** pin the result to the unsigned range of the lane.
- **Signed clamp:** pin the result to the two's-complement range of the lane.

The typical use is pixel and sample arithmetic, where wrapping would turn a bright pixel into a dark one. The result is registered, so it is valid one clock after the operands are presented.

Top module: `packed_sat_adder`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to zero. Outside reset, `result` shows the outcome for the inputs sampled at the previous rising clock edge.
- R2: `lane_sel` selects the lane width:
  - 0 gives 8-bit lanes.
  - 1 gives 16-bit lanes.
  - 2 and 3 both give 32-bit lanes.
- R3: No carry or borrow crosses a lane boundary. Lane k of width n occupies bits [n*k+n-1 : n*k] and depends only on the same bits of `opa` and `opb`.
- R4: `sub` = 0 computes opa + opb for each lane, and `sub` = 1 computes opa − opb. Both directions support every lane width and every arithmetic mode.
- R5: `arith_sel` 0 or 3 selects wrap mode. In wrap mode each lane result is the exact result modulo 2^n, with no overflow detection.
- R6: `arith_sel` 1 selects unsigned clamping:
  - An overflow gives 2^n−1.
  - An underflow gives 0.
  - An in-range result is exact.
- R7: `arith_sel` 2 selects signed clamping on two's-complement lanes:
  - An overflow gives 2^(n−1)−1.
  - An underflow gives −2^(n−1).
  - An in-range result is exact.
- R8: With 32-bit lanes, a clamping mode (1 or 2) behaves as wrap mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 64 | First packed operand (minuend for subtraction) |
| opb | input | 64 | Second packed operand |
| lane_sel | input | 2 | Lane width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| sub | input | 1 | 0 = add, 1 = subtract |
| arith_sel | input | 2 | 0/3 = wrap, 1 = unsigned clamp, 2 = signed clamp |
| result | output | 64 | Registered packed result |

## Verification
The embedded properties assume that `lane_sel`, `sub`, `arith_sel` and both operands are known (not X) at every rising edge outside reset. They also assume that these inputs are held for the whole clock period in which they are sampled. The bench keeps within this by driving every input on the falling edge, starting from defined values at time zero with reset asserted. It then reads `result` at the following falling edge. The lane-wise ordering properties also assume that an 8-bit clamping operation is judged against the operands of the same cycle. The bench guarantees this by holding each input set for exactly one clock.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    LANE_B8   = 2'd0,
    LANE_B16  = 2'd1,
    LANE_B32  = 2'd2,
    LANE_B32X = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    ARITH_WRAP  = 2'd0,
    ARITH_USAT  = 2'd1,
    ARITH_SSAT  = 2'd2,
    ARITH_WRAPX = 2'd3
  } arith_e;

  // number of byte slices in one lane for a given select code
  function automatic logic [2:0] slices_per_lane(input logic [1:0] sel);
    case (sel)
      LANE_B8:  return 3'd1;
      LANE_B16: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/slice_adder.sv
module slice_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_msb
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  assign b_eff = sub ? ~b : b;
  assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = total[W-1:0];
  assign cout  = total[W];
  // carry into the top bit, needed for signed overflow detection
  assign c_msb = total[W-1] ^ a[W-1] ^ b_eff[W-1];
endmodule

// File: rtl/slice_clamp.sv
module slice_clamp #(
  parameter int W = 8
) (
  input  logic [W-1:0] sum_in,
  input  logic         sat_u,
  input  logic         sat_s,
  input  logic         ovf_u,
  input  logic         ovf_s,
  input  logic         sub,
  input  logic         a_neg,
  input  logic         is_top,
  output logic [W-1:0] sum_out
);
  always_comb begin
    if (sat_u && ovf_u) begin
      sum_out = sub ? '0 : '1;
    end else if (sat_s && ovf_s) begin
      if (a_neg)
        sum_out = is_top ? {1'b1, {(W-1){1'b0}}} : '0;
      else
        sum_out = is_top ? {1'b0, {(W-1){1'b1}}} : '1;
    end else begin
      sum_out = sum_in;
    end
  end
endmodule

// File: rtl/packed_sat_adder.sv
module packed_sat_adder
  import psa_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        lane_sel,
  input  logic              sub,
  input  logic [1:0]        arith_sel,
  output logic [DATA_W-1:0] result
);
  localparam int NSL = DATA_W / SLICE_W;
  localparam int IW  = (NSL > 1) ? $clog2(NSL) : 1;

  logic [2:0]        span;
  logic              sat_u, sat_s;
  logic [NSL-1:0]    cin_v, cout_v, cmsb_v;
  logic [DATA_W-1:0] raw_sum, next_res;

  assign span  = slices_per_lane(lane_sel);
  // 32-bit lanes never clamp
  assign sat_u = (arith_sel == ARITH_USAT) && !lane_sel[1];
  assign sat_s = (arith_sel == ARITH_SSAT) && !lane_sel[1];

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    logic          lane_start;
    logic [IW-1:0] top_idx;
    logic          ovf_u, ovf_s, a_neg;

    assign lane_start = ((IW'(i) & IW'(span - 3'd1)) == '0);
    assign top_idx    = IW'(i) | IW'(span - 3'd1);

    if (i == 0) begin : g_first
      assign cin_v[i] = sub;
    end else begin : g_chain
      assign cin_v[i] = lane_start ? sub : cout_v[i-1];
    end

    slice_adder #(.W(SLICE_W)) u_add (
      .a    (opa[i*SLICE_W +: SLICE_W]),
      .b    (opb[i*SLICE_W +: SLICE_W]),
      .sub  (sub),
      .cin  (cin_v[i]),
      .sum  (raw_sum[i*SLICE_W +: SLICE_W]),
      .cout (cout_v[i]),
      .c_msb(cmsb_v[i])
    );

    // lane flags come from the most significant slice of the lane
    assign ovf_u = sub ? ~cout_v[top_idx] : cout_v[top_idx];
    assign ovf_s = cout_v[top_idx] ^ cmsb_v[top_idx];
    assign a_neg = opa[{top_idx, 3'b111}];

    slice_clamp #(.W(SLICE_W)) u_clamp (
      .sum_in (raw_sum[i*SLICE_W +: SLICE_W]),
      .sat_u  (sat_u),
      .sat_s  (sat_s),
      .ovf_u  (ovf_u),
      .ovf_s  (ovf_s),
      .sub    (sub),
      .a_neg  (a_neg),
      .is_top (top_idx == IW'(i)),
      .sum_out(next_res[i*SLICE_W +: SLICE_W])
    );

    // byte-lane ordering properties
    AST_USAT_ADD_GE: assert property (@(posedge clk) disable iff (rst)
      (lane_sel == LANE_B8 && arith_sel == ARITH_USAT && !sub)
      |=> (result[i*SLICE_W +: SLICE_W] >= $past(opa[i*SLICE_W +: SLICE_W]))); // R6
    AST_USAT_SUB_LE: assert property (@(posedge clk) disable iff (rst)
      (lane_sel == LANE_B8 && arith_sel == ARITH_USAT && sub)
      |=> (result[i*SLICE_W +: SLICE_W] <= $past(opa[i*SLICE_W +: SLICE_W]))); // R6
    AST_SSAT_POS_KEEP: assert property (@(posedge clk) disable iff (rst)
      (lane_sel == LANE_B8 && arith_sel == ARITH_SSAT && !sub
       && !opa[i*SLICE_W+SLICE_W-1] && !opb[i*SLICE_W+SLICE_W-1])
      |=> !result[i*SLICE_W+SLICE_W-1]); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (result == '0)); // R1
  AST_WIDE_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (lane_sel[1] && !sub)
    |=> (result[31:0] == 32'($past(opa[31:0]) + $past(opb[31:0])))); // R8
  AST_WIDE_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
    (lane_sel[1] && sub)
    |=> (result[31:0] == 32'($past(opa[31:0]) - $past(opb[31:0])))); // R4
endmodule

// File: tb/packed_sat_adder_bench.sv
module packed_sat_adder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opa = '0, opb = '0;
  logic [1:0]  lane_sel = 2'd0, arith_sel = 2'd0;
  logic        sub = 1'b0;
  logic [63:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  packed_sat_adder u_packed_sat_adder (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb),
    .lane_sel(lane_sel), .sub(sub), .arith_sel(arith_sel), .result(result)
  );

  // independent lane model
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] ls, input logic s, input logic [1:0] md);
    int n;
    logic [63:0] r;
    longint mask, ua, ub, sa, sb, v;
    n = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    r = '0;
    mask = (longint'(1) <<< n) - 1;
    for (int k = 0; k < 64 / n; k++) begin
      ua = longint'((a >> (k * n))) & mask;
      ub = longint'((b >> (k * n))) & mask;
      if (n < 32 && md == 2'd1) begin
        v = s ? ua - ub : ua + ub;
        if (v > mask) v = mask;
        if (v < 0) v = 0;
      end else if (n < 32 && md == 2'd2) begin
        sa = (ua > (mask >>> 1)) ? ua - (mask + 1) : ua;
        sb = (ub > (mask >>> 1)) ? ub - (mask + 1) : ub;
        v = s ? sa - sb : sa + sb;
        if (v > (mask >>> 1)) v = mask >>> 1;
        if (v < -((mask >>> 1) + 1)) v = -((mask >>> 1) + 1);
        v = v & mask;
      end else begin
        v = (s ? ua - ub : ua + ub) & mask;
      end
      r = r | (64'(v) << (k * n));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] ls, input logic s, input logic [1:0] md);
    @(negedge clk);
    opa = a; opb = b; lane_sel = ls; sub = s; arith_sel = md;
    @(negedge clk);
    check(req, result, model(a, b, ls, s, md));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset", result, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_wrap8();
    run_op("R5 wrap8 add", 64'hFF80_7F01_00FE_1234, 64'h0180_0101_FF03_4321, 2'd0, 1'b0, 2'd0);
    run_op("R5 wrap8 sub", 64'h0000_8000_7F10_0001, 64'h0100_0180_FF20_0102, 2'd0, 1'b1, 2'd3);
    // R3: FF+01 in every byte must give 00 with no carry into neighbours
    run_op("R3 byte isolation", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 1'b0, 2'd0);
    check("R3 isolation value", result, 64'h0);
  endtask

  task automatic t_usat();
    run_op("R6 usat8 add", 64'hFFF0_8001_0000_7F7F, 64'h0120_8000_FF00_8081, 2'd0, 1'b0, 2'd1);
    check("R6 usat8 add clamp", result[63:48], 16'hFFFF);
    run_op("R6 usat8 sub", 64'h0010_FF00_0080_0102, 64'h0120_00FF_0081_0201, 2'd0, 1'b1, 2'd1);
    run_op("R6 usat16 add", 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFE_0001, 2'd1, 1'b0, 2'd1);
    run_op("R6 usat16 sub", 64'h0000_1000_FFFF_0005, 64'h0001_0FFF_FFFF_0006, 2'd1, 1'b1, 2'd1);
  endtask

  task automatic t_ssat();
    run_op("R7 ssat8 add", 64'h7F80_7F80_FF01_4040, 64'h0180_7FFF_FF01_4040, 2'd0, 1'b0, 2'd2);
    check("R7 ssat8 clamp", result[63:48], 16'h7F80);
    run_op("R7 ssat8 sub", 64'h807F_0080_FF00_7F80, 64'h01FF_8001_7F01_807F, 2'd0, 1'b1, 2'd2);
    run_op("R7 ssat16 add", 64'h7FFF_8000_FFFF_4000, 64'h0001_FFFF_FFFF_4000, 2'd1, 1'b0, 2'd2);
    check("R7 ssat16 clamp", result, 64'h7FFF_8000_FFFE_7FFF);
    run_op("R7 ssat16 sub", 64'h8000_7FFF_0000_0001, 64'h0001_FFFF_8000_0002, 2'd1, 1'b1, 2'd2);
  endtask

  task automatic t_wide();
    run_op("R8 32 usat as wrap", 64'hFFFF_FFFF_8000_0000, 64'h0000_0002_8000_0000, 2'd2, 1'b0, 2'd1);
    check("R8 wrap value", result, 64'h0000_0001_0000_0000);
    run_op("R8 32 ssat as wrap", 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 2'd3, 1'b0, 2'd2);
    check("R2 code3 is 32", result, 64'h8000_0000_0000_0001);
    run_op("R4 32 sub", 64'h0000_0000_1234_5678, 64'h0000_0001_0000_0001, 2'd2, 1'b1, 2'd0);
    run_op("R3 16 isolation", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'd1, 1'b0, 2'd0);
  endtask

  task automatic t_random();
    logic [63:0] pool [4];
    logic [63:0] a, b;
    pool[0] = 64'h0; pool[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pool[2] = 64'h8080_8000_8000_8000; pool[3] = 64'h7F7F_7FFF_7FFF_FFFF;
    for (int i = 0; i < 300; i++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 5 == 0) a = pool[i % 4];
      if (i % 7 == 0) b = pool[(i / 7) % 4];
      run_op("R2 random lanes", a, b, 2'($urandom), 1'($urandom), 2'($urandom));
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wrap8();
    t_usat();
    t_ssat();
    t_wide();
    t_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule